// File: doc/BRIEF.md
# Endpoint DMA Request Sequencer

This block paces the handshake between an external DMA controller and one bulk endpoint FIFO. It raises a request pin when the endpoint has something to move, qualifies each transfer beat with an acknowledge pin (single-address mode) or a bus strobe (dual-address mode), and moves one byte or one 16-bit word per beat. In receive direction it streams a whole packet out of the FIFO. It can put the packet's byte count in front of the data, and it pulses a release for the receive-ready flag once the last byte has gone. In transmit direction it pushes beats into the FIFO and pulses a set for the transmit-ready flag once the written bytes reach the programmed maximum packet size.

In demand mode the request stays up for the whole packet. In single mode it drops after every beat and stays down for a programmable interval counted in 12 MHz bit times. The `TICK_DIV` parameter gives the number of `clk` cycles per bit time. The request and acknowledge polarities are each selectable, and both default to active-low.

The receive data port follows valid/ready rules. `rd_valid` marks an offered beat, the resolved qualifier acts as ready, and `rd_data` holds steady until a beat is taken. The transmit port mirrors this: `wr_ready` marks that a beat will be accepted, the qualifier acts as valid, and `wr_data` is sampled on that edge. The configuration must stay unchanged while a packet is in flight.

Top module: `epdma_seq`

## Requirements
- R1: While reset is held, the request pin is inactive, `fifo_pop` and `fifo_push` are 0, and `rx_clr` and `tx_set` are 0.
- R2: The request pin equals the internal request when `cfg_dreq_hi`=1 and its inverse when 0. The acknowledge pin counts as active when it equals `cfg_dack_hi`. `rd_valid` is high only while the request is active in receive direction (`cfg_tx`=0), and `wr_ready` is high only while it is active in transmit direction.
- R3: The request is active only when `cfg_en`=1 and, in receive direction, `ep_rx_full`=1, or, in transmit direction, `ep_tx_armed`=0. A packet starts on the edge after those conditions hold in the idle state.
- R4: Byte mode receive: each beat carries one byte in `rd_data[7:0]` with the upper lane 00h. With `cfg_hdr`=1 the first beat carries the byte count and pops nothing. Every data beat pops exactly one FIFO byte, in FIFO order.
- R5: Word mode receive (`cfg_wide`=1): the earlier byte sits in `rd_data[7:0]`. The header word is {00h, count}. A data beat pops 2 bytes, except the final beat of an odd packet, which pops 1 and carries 00h in `rd_data[15:8]`.
- R6: After the final receive beat (or at once for an empty packet with no header), `rx_clr` pulses for exactly one cycle. No new packet starts until `ep_rx_full` has fallen and risen again.
- R7: Transmit: each beat pushes `wr_data` (one byte in byte mode, two in word mode, one on an odd final beat), with the earlier byte in the low lane. When the pushed total reaches `cfg_mps`, `tx_set` pulses for one cycle. A zero `cfg_mps` pulses it without any beat.
- R8: Demand mode (`cfg_demand`=1): the request stays active from beat to beat until the packet completes.
- R9: Single mode: after each non-final beat the request is inactive for exactly `cfg_gap`*TICK_DIV+1 clock cycles before it reasserts.
- R10: Dual-address mode (`cfg_dual`=1): beats are qualified by `bus_stb` alone, and the acknowledge pin has no effect. In single-address mode `bus_stb` has no effect.
- R11: Clearing `cfg_en` makes the request inactive in the same cycle and cancels any running interval. After it is re-enabled, a pending packet requests again one edge later, without waiting out the old interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | DMA enable |
| cfg_dual | input | 1 | 0 single-address (acknowledge qualifies), 1 dual-address (strobe qualifies) |
| cfg_hdr | input | 1 | Prefix receive stream with the byte count |
| cfg_wide | input | 1 | 0 byte beats, 1 16-bit beats |
| cfg_demand | input | 1 | 0 single mode, 1 demand mode |
| cfg_tx | input | 1 | Endpoint direction: 0 receive, 1 transmit |
| cfg_gap | input | 8 | Single-mode interval in bit times |
| cfg_dreq_hi | input | 1 | Request pin active-high when 1 |
| cfg_dack_hi | input | 1 | Acknowledge pin active-high when 1 |
| cfg_mps | input | CNT_W | Maximum packet size for transmit |
| dreq_pin | output | 1 | DMA request pin |
| dack_pin | input | 1 | DMA acknowledge pin |
| bus_stb | input | 1 | Transfer strobe used in dual-address mode |
| ep_rx_full | input | 1 | Endpoint receive-ready flag |
| ep_rx_cnt | input | CNT_W | Received packet byte count |
| ep_tx_armed | input | 1 | Endpoint transmit-ready flag |
| fifo_head | input | 2*LANE_W | Two oldest FIFO bytes, oldest in the low lane |
| fifo_pop | output | 2 | Bytes popped this cycle (0..2) |
| fifo_wdata | output | 2*LANE_W | Bytes pushed, earlier byte in the low lane |
| fifo_push | output | 2 | Bytes pushed this cycle (0..2) |
| rx_clr | output | 1 | One-cycle pulse: release the receive-ready flag |
| tx_set | output | 1 | One-cycle pulse: set the transmit-ready flag |
| rd_data | output | 2*LANE_W | Receive beat toward the DMA controller |
| rd_valid | output | 1 | A receive beat is offered |
| wr_data | input | 2*LANE_W | Transmit beat from the DMA controller |
| wr_ready | output | 1 | A transmit beat will be accepted |

## Verification
Random receive packets with lengths from 0 to 64 are run under every mix of header, width, single or demand mode, address mode and pin polarity. Even and odd lengths separate the padded final word from a full one, and empty packets separate header-only and release-only sequences. Random transmit packets with even, odd and zero maximum sizes cover the partial last push and the set pulse. The DMA side stalls at random, with noise on the unused qualifier, so that qualification, back-pressure and address-mode selection all show up in the data order. Directed cases measure the exact interval length, cover flag gating, and cover disabling mid-burst and mid-interval.

// File: rtl/epdma_pkg.sv
package epdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MOVE,
    ST_HOLD,
    ST_DONE,
    ST_PARK
  } seq_st_e;
endpackage

// File: rtl/epdma_gap.sv
// Interval timer: counts GAP_W-bit bit times, each TICK_DIV clock cycles.
module epdma_gap #(
  parameter int TICK_DIV = 8,
  parameter int GAP_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             start,
  input  logic [GAP_W-1:0] gap,
  output logic             expired
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic             run_q;
  logic [GAP_W-1:0] left_q;
  logic [PRE_W-1:0] pre_q;

  assign expired = run_q && (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      left_q <= '0;
      pre_q  <= '0;
    end else if (kill) begin
      run_q  <= 1'b0;
      left_q <= '0;
      pre_q  <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      left_q <= gap;
      pre_q  <= '0;
    end else if (run_q) begin
      if (left_q == '0) begin
        run_q <= 1'b0;
      end else if (pre_q == PRE_LAST) begin
        pre_q  <= '0;
        left_q <= left_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/epdma_fmt.sv
// Lane formatting: beat width, header word, odd-byte padding, pop/push counts.
module epdma_fmt #(
  parameter int LANE_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic                dir_tx,
  input  logic                wide,
  input  logic                hdr_pend,
  input  logic                beat,
  input  logic [CNT_W-1:0]    rem,
  input  logic [2*LANE_W-1:0] fifo_head,
  input  logic [2*LANE_W-1:0] wr_data,
  output logic [1:0]          take,
  output logic [2*LANE_W-1:0] rd_data,
  output logic [2*LANE_W-1:0] fifo_wdata,
  output logic [1:0]          fifo_pop,
  output logic [1:0]          fifo_push
);
  localparam logic [LANE_W-1:0] PAD = '0;

  logic two;

  assign two  = wide && (rem > CNT_W'(1));
  assign take = (rem == '0) ? 2'd0 : (two ? 2'd2 : 2'd1);

  always_comb begin
    if (hdr_pend) begin
      rd_data = {PAD, LANE_W'(rem)};
    end else begin
      rd_data = {two ? fifo_head[2*LANE_W-1:LANE_W] : PAD, fifo_head[LANE_W-1:0]};
    end
  end

  assign fifo_wdata = {two ? wr_data[2*LANE_W-1:LANE_W] : PAD, wr_data[LANE_W-1:0]};
  assign fifo_pop   = (beat && !dir_tx && !hdr_pend) ? take : 2'd0;
  assign fifo_push  = (beat && dir_tx) ? take : 2'd0;
endmodule

// File: rtl/epdma_ctrl.sv
// Packet sequencer: start conditions, remaining count, mode stepping, flag hand-off.
module epdma_ctrl
  import epdma_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dir_tx,
  input  logic             hdr,
  input  logic             demand,
  input  logic             rx_full,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             tx_armed,
  input  logic [CNT_W-1:0] mps,
  input  logic             qual,
  input  logic             gap_expired,
  input  logic [1:0]       take,
  output logic             act,
  output logic             beat,
  output logic             gap_start,
  output logic             rx_clr,
  output logic             tx_set,
  output logic             hdr_pend,
  output logic [CNT_W-1:0] rem
);
  seq_st_e          st_q;
  logic             hdr_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_nx;
  logic             flag_ok;
  logic             pending;
  logic             last;

  assign flag_ok = dir_tx ? !tx_armed : rx_full;
  assign pending = hdr_q || (rem_q != '0);
  assign rem_nx  = hdr_q ? rem_q : (rem_q - CNT_W'(take));
  assign last    = (rem_nx == '0);

  assign act       = en && (st_q == ST_MOVE) && pending && flag_ok;
  assign beat      = act && qual;
  assign gap_start = beat && !last && !demand;
  assign rx_clr    = en && (st_q == ST_DONE) && !dir_tx;
  assign tx_set    = en && (st_q == ST_DONE) && dir_tx;
  assign hdr_pend  = hdr_q;
  assign rem       = rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      hdr_q <= 1'b0;
      rem_q <= '0;
    end else if (!en) begin
      st_q  <= ST_IDLE;
      hdr_q <= 1'b0;
      rem_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (dir_tx && !tx_armed) begin
            rem_q <= mps;
            hdr_q <= 1'b0;
            st_q  <= ST_MOVE;
          end else if (!dir_tx && rx_full) begin
            rem_q <= rx_cnt;
            hdr_q <= hdr;
            st_q  <= ST_MOVE;
          end
        end
        ST_MOVE: begin
          if (!pending) begin
            st_q <= ST_DONE;
          end else if (beat) begin
            rem_q <= rem_nx;
            hdr_q <= 1'b0;
            if (last)         st_q <= ST_DONE;
            else if (!demand) st_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (gap_expired) st_q <= ST_MOVE;
        end
        ST_DONE: st_q <= ST_PARK;
        ST_PARK: begin
          if (dir_tx ? tx_armed : !rx_full) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epdma_seq.sv
module epdma_seq #(
  parameter int LANE_W   = 8,
  parameter int MAX_PKT  = 64,
  parameter int TICK_DIV = 8,
  parameter int GAP_W    = 8,
  parameter int CNT_W    = $clog2(MAX_PKT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_en,
  input  logic                cfg_dual,
  input  logic                cfg_hdr,
  input  logic                cfg_wide,
  input  logic                cfg_demand,
  input  logic                cfg_tx,
  input  logic [GAP_W-1:0]    cfg_gap,
  input  logic                cfg_dreq_hi,
  input  logic                cfg_dack_hi,
  input  logic [CNT_W-1:0]    cfg_mps,
  output logic                dreq_pin,
  input  logic                dack_pin,
  input  logic                bus_stb,
  input  logic                ep_rx_full,
  input  logic [CNT_W-1:0]    ep_rx_cnt,
  input  logic                ep_tx_armed,
  input  logic [2*LANE_W-1:0] fifo_head,
  output logic [1:0]          fifo_pop,
  output logic [2*LANE_W-1:0] fifo_wdata,
  output logic [1:0]          fifo_push,
  output logic                rx_clr,
  output logic                tx_set,
  output logic [2*LANE_W-1:0] rd_data,
  output logic                rd_valid,
  input  logic [2*LANE_W-1:0] wr_data,
  output logic                wr_ready
);
  logic             act;
  logic             beat;
  logic             qual;
  logic             dack_on;
  logic             gap_start;
  logic             gap_expired;
  logic             hdr_pend;
  logic [CNT_W-1:0] rem;
  logic [1:0]       take;

  assign dack_on  = cfg_dack_hi ? dack_pin : !dack_pin;
  assign qual     = cfg_dual ? bus_stb : dack_on;
  assign dreq_pin = cfg_dreq_hi ? act : !act;
  assign rd_valid = act && !cfg_tx;
  assign wr_ready = act && cfg_tx;

  epdma_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (cfg_en),
    .dir_tx      (cfg_tx),
    .hdr         (cfg_hdr),
    .demand      (cfg_demand),
    .rx_full     (ep_rx_full),
    .rx_cnt      (ep_rx_cnt),
    .tx_armed    (ep_tx_armed),
    .mps         (cfg_mps),
    .qual        (qual),
    .gap_expired (gap_expired),
    .take        (take),
    .act         (act),
    .beat        (beat),
    .gap_start   (gap_start),
    .rx_clr      (rx_clr),
    .tx_set      (tx_set),
    .hdr_pend    (hdr_pend),
    .rem         (rem)
  );

  epdma_gap #(.TICK_DIV(TICK_DIV), .GAP_W(GAP_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .kill    (!cfg_en),
    .start   (gap_start),
    .gap     (cfg_gap),
    .expired (gap_expired)
  );

  epdma_fmt #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_fmt (
    .dir_tx     (cfg_tx),
    .wide       (cfg_wide),
    .hdr_pend   (hdr_pend),
    .beat       (beat),
    .rem        (rem),
    .fifo_head  (fifo_head),
    .wr_data    (wr_data),
    .take       (take),
    .rd_data    (rd_data),
    .fifo_wdata (fifo_wdata),
    .fifo_pop   (fifo_pop),
    .fifo_push  (fifo_push)
  );
endmodule

// File: rtl/epdma_seq_chk.sv
module epdma_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_en,
  input logic       cfg_tx,
  input logic       cfg_dual,
  input logic       cfg_demand,
  input logic       cfg_dreq_hi,
  input logic       cfg_dack_hi,
  input logic       dreq_pin,
  input logic       dack_pin,
  input logic       bus_stb,
  input logic       ep_rx_full,
  input logic       ep_tx_armed,
  input logic [1:0] fifo_pop,
  input logic [1:0] fifo_push,
  input logic       rx_clr,
  input logic       tx_set,
  input logic       rd_valid,
  input logic       wr_ready
);
  logic req_on;
  logic q_on;

  assign req_on = cfg_dreq_hi ? dreq_pin : !dreq_pin;
  assign q_on   = cfg_dual ? bus_stb : (dack_pin == cfg_dack_hi);

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) !cfg_en |-> !req_on); // R11
  AST_RX_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n) (req_on && !cfg_tx) |-> ep_rx_full); // R3
  AST_TX_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n) (req_on && cfg_tx) |-> !ep_tx_armed); // R3
  AST_VALID_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid || wr_ready) |-> req_on); // R2
  AST_POP_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n) (fifo_pop != 2'd0) |-> (rd_valid && q_on)); // R4
  AST_PUSH_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n) (fifo_push != 2'd0) |-> (wr_ready && q_on)); // R7
  AST_DUAL_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n) (cfg_dual && !bus_stb) |-> (fifo_pop == 2'd0 && fifo_push == 2'd0)); // R10
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rx_clr |=> !rx_clr); // R6
  AST_SET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) tx_set |=> !tx_set); // R7
  AST_SINGLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (req_on && q_on && !cfg_demand) |=> !req_on); // R9
endmodule

bind epdma_seq epdma_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_en      (cfg_en),
  .cfg_tx      (cfg_tx),
  .cfg_dual    (cfg_dual),
  .cfg_demand  (cfg_demand),
  .cfg_dreq_hi (cfg_dreq_hi),
  .cfg_dack_hi (cfg_dack_hi),
  .dreq_pin    (dreq_pin),
  .dack_pin    (dack_pin),
  .bus_stb     (bus_stb),
  .ep_rx_full  (ep_rx_full),
  .ep_tx_armed (ep_tx_armed),
  .fifo_pop    (fifo_pop),
  .fifo_push   (fifo_push),
  .rx_clr      (rx_clr),
  .tx_set      (tx_set),
  .rd_valid    (rd_valid),
  .wr_ready    (wr_ready)
);

// File: tb/epdma_seq_bench.sv
`timescale 1ns/1ps
module epdma_seq_bench;
  localparam int LW  = 8;
  localparam int DIV = 8;
  localparam int CW  = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_en = 1'b0, cfg_dual = 1'b0, cfg_hdr = 1'b0, cfg_wide = 1'b0;
  logic          cfg_demand = 1'b0, cfg_tx = 1'b0, cfg_dreq_hi = 1'b0, cfg_dack_hi = 1'b0;
  logic [7:0]    cfg_gap = 8'd0;
  logic [CW-1:0] cfg_mps = '0;
  logic          dreq_pin;
  logic          dack_pin = 1'b1;
  logic          bus_stb = 1'b0;
  logic          ep_rx_full = 1'b0;
  logic [CW-1:0] ep_rx_cnt = '0;
  logic          ep_tx_armed = 1'b1;
  logic [15:0]   fifo_head;
  logic [1:0]    fifo_pop;
  logic [15:0]   fifo_wdata;
  logic [1:0]    fifo_push;
  logic          rx_clr, tx_set;
  logic [15:0]   rd_data;
  logic          rd_valid;
  logic [15:0]   wr_data = '0;
  logic          wr_ready;

  epdma_seq #(.LANE_W(LW), .MAX_PKT(64), .TICK_DIV(DIV), .GAP_W(8)) u_epdma_seq (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dual(cfg_dual), .cfg_hdr(cfg_hdr),
    .cfg_wide(cfg_wide), .cfg_demand(cfg_demand), .cfg_tx(cfg_tx), .cfg_gap(cfg_gap),
    .cfg_dreq_hi(cfg_dreq_hi), .cfg_dack_hi(cfg_dack_hi), .cfg_mps(cfg_mps),
    .dreq_pin(dreq_pin), .dack_pin(dack_pin), .bus_stb(bus_stb),
    .ep_rx_full(ep_rx_full), .ep_rx_cnt(ep_rx_cnt), .ep_tx_armed(ep_tx_armed),
    .fifo_head(fifo_head), .fifo_pop(fifo_pop), .fifo_wdata(fifo_wdata), .fifo_push(fifo_push),
    .rx_clr(rx_clr), .tx_set(tx_set), .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_data(wr_data), .wr_ready(wr_ready)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] rxm [128];
  logic [7:0] txm [128];
  int   hp = 0, wp = 0;
  logic ptr_clr = 1'b0;
  int   exp_w [80];
  int   exp_n = 0;
  logic [7:0] exp_b [128];

  assign fifo_head = {rxm[(hp + 1) % 128], rxm[hp % 128]};

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (ptr_clr) begin
      hp <= 0;
      wp <= 0;
    end else begin
      hp <= hp + int'(fifo_pop);
      if (fifo_push != 2'd0) begin
        txm[wp % 128] <= fifo_wdata[7:0];
        if (fifo_push == 2'd2) txm[(wp + 1) % 128] <= fifo_wdata[15:8];
        wp <= wp + int'(fifo_push);
      end
    end
  end

  function automatic bit req_on();
    return cfg_dreq_hi ? dreq_pin : !dreq_pin;
  endfunction

  // Expected receive stream from the requirements (R4, R5).
  function automatic void build_rx(int n, bit hdr, bit wide);
    int k = 0;
    int i = 0;
    if (hdr) begin exp_w[k] = n; k++; end
    while (i < n) begin
      if (wide) begin
        exp_w[k] = int'(rxm[i]) + ((i + 1 < n) ? int'(rxm[i + 1]) * 256 : 0);
        i += 2;
      end else begin
        exp_w[k] = int'(rxm[i]);
        i += 1;
      end
      k++;
    end
    exp_n = k;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic qual(bit on);
    if (cfg_dual) begin
      bus_stb  = on;
      dack_pin = $urandom % 2;
    end else begin
      bus_stb  = $urandom % 2;
      dack_pin = on ? cfg_dack_hi : !cfg_dack_hi;
    end
  endtask

  // After a non-final beat: R8 in demand mode, R9 in single mode.
  task automatic after_beat(int gap);
    int low = 0;
    if (cfg_demand) begin
      chk("R8 request held in demand mode", int'(req_on()), 1);
    end else begin
      while (!req_on() && low < 4000) begin
        low++;
        @(negedge clk);
      end
      chk("R9 single-mode gap length", low, gap * DIV + 1);
    end
  endtask

  task automatic run_rx(int n, bit hdr, bit wide, bit dem, bit dual, int gap);
    int beat = 0;
    int guard = 0;
    bit done = 0;
    @(negedge clk);
    cfg_tx = 0; cfg_hdr = hdr; cfg_wide = wide; cfg_demand = dem; cfg_dual = dual;
    cfg_gap = 8'(gap); cfg_dreq_hi = $urandom % 2; cfg_dack_hi = $urandom % 2;
    qual(0);
    for (int i = 0; i < 128; i++) rxm[i] = 8'($urandom);
    build_rx(n, hdr, wide);
    ptr_clr = 1;
    @(negedge clk);
    ptr_clr = 0; ep_rx_cnt = CW'(n); ep_rx_full = 1; cfg_en = 1;
    while (!done && guard < 20000) begin
      guard++;
      @(negedge clk);
      if (rx_clr) begin
        chk("R6 release after empty stream", beat, exp_n);
        ep_rx_full = 0;
        done = 1;
      end else if (req_on()) begin
        chk("R2 valid follows request (rx)", int'(rd_valid), 1);
        if ($urandom % 3 == 0) begin
          int hp0 = hp;
          qual(0);
          @(negedge clk);
          chk("R10 no beat without the selected qualifier", hp, hp0);
        end
        chk(wide ? "R5 word data" : "R4 byte data", int'(rd_data), exp_w[beat]);
        qual(1);
        @(negedge clk);
        qual(0);
        beat++;
        if (beat == exp_n) begin
          chk("R6 release pulse after final beat", int'(rx_clr), 1);
          chk("R6 request off after final beat", int'(req_on()), 0);
          ep_rx_full = 0;
          done = 1;
          @(negedge clk);
          chk("R6 release lasts one cycle", int'(rx_clr), 0);
        end else begin
          after_beat(gap);
        end
      end
    end
    @(negedge clk);
    chk(wide ? "R5 bytes popped" : "R4 bytes popped", hp, n);
  endtask

  task automatic run_tx(int mps, bit wide, bit dem, bit dual, int gap);
    int r = mps;
    int nb = 0;
    int guard = 0;
    bit done = 0;
    @(negedge clk);
    cfg_tx = 1; cfg_hdr = $urandom % 2; cfg_wide = wide; cfg_demand = dem; cfg_dual = dual;
    cfg_gap = 8'(gap); cfg_dreq_hi = $urandom % 2; cfg_dack_hi = $urandom % 2;
    cfg_mps = CW'(mps);
    qual(0);
    ptr_clr = 1;
    @(negedge clk);
    ptr_clr = 0; ep_tx_armed = 0; cfg_en = 1;
    while (!done && guard < 20000) begin
      guard++;
      @(negedge clk);
      if (tx_set) begin
        chk("R7 set pulse for zero size", r, 0);
        ep_tx_armed = 1;
        done = 1;
      end else if (req_on()) begin
        logic [15:0] d;
        chk("R2 ready follows request (tx)", int'(wr_ready), 1);
        d = 16'($urandom);
        wr_data = d;
        exp_b[nb] = d[7:0]; nb++;
        if (wide && r >= 2) begin exp_b[nb] = d[15:8]; nb++; r -= 2; end
        else r -= 1;
        qual(1);
        @(negedge clk);
        qual(0);
        wr_data = 16'($urandom);
        if (r == 0) begin
          chk("R7 set pulse at max size", int'(tx_set), 1);
          ep_tx_armed = 1;
          done = 1;
        end else begin
          after_beat(gap);
        end
      end
    end
    @(negedge clk);
    chk("R7 bytes pushed", wp, mps);
    for (int i = 0; i < nb; i++) chk("R7 pushed byte order", int'(txm[i]), int'(exp_b[i]));
  endtask

  initial begin
    process::self().srandom(32'h5EED_0417);
    for (int i = 0; i < 128; i++) begin rxm[i] = '0; txm[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 request pin inactive (high) in reset", int'(dreq_pin), 1);
    chk("R1 no pop/push in reset", int'(fifo_pop) + int'(fifo_push), 0);
    chk("R1 no flag pulses in reset", int'(rx_clr) + int'(tx_set), 0);
    rst_n = 1;
    @(negedge clk);

    // R3 gating: enabled but no ready flag / armed transmit
    cfg_en = 1; cfg_tx = 0; ep_rx_full = 0;
    repeat (10) @(negedge clk);
    chk("R3 no rx request without full flag", int'(req_on()), 0);
    cfg_tx = 1; ep_tx_armed = 1;
    repeat (10) @(negedge clk);
    chk("R3 no tx request while armed", int'(req_on()), 0);
    cfg_en = 0; cfg_tx = 0;
    @(negedge clk);

    // R2 polarity directed
    cfg_dreq_hi = 1; ep_rx_cnt = 7'd4; ep_rx_full = 1; cfg_en = 1;
    repeat (2) @(negedge clk);
    chk("R2 active-high request pin", int'(dreq_pin), 1);
    cfg_dreq_hi = 0;
    #1 chk("R2 active-low request pin", int'(dreq_pin), 0);
    cfg_en = 0; ep_rx_full = 0;
    repeat (2) @(negedge clk);

    // Directed corner packets
    run_rx(5, 1, 1, 0, 0, 2);    // header + odd word
    run_rx(4, 0, 1, 1, 1, 0);    // even word, demand, dual
    run_rx(0, 1, 0, 1, 0, 0);    // header only
    run_rx(0, 0, 1, 0, 0, 1);    // empty: release only
    run_rx(64, 0, 0, 1, 0, 0);   // full size bytes
    run_rx(3, 0, 0, 0, 0, 255);  // longest gap
    run_tx(7, 1, 0, 0, 1);       // odd size words
    run_tx(0, 0, 1, 0, 0);       // zero size
    run_tx(64, 1, 1, 1, 0);

    // Random mix
    for (int p = 0; p < 40; p++) begin
      if ($urandom % 2)
        run_rx($urandom % 65, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 4);
      else
        run_tx($urandom % 65, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 4);
    end

    // R11: disable during the interval, then re-enable
    @(negedge clk);
    cfg_en = 0; cfg_tx = 0; cfg_hdr = 0; cfg_wide = 0; cfg_demand = 0; cfg_dual = 0;
    cfg_gap = 8'd255; cfg_dreq_hi = 0; cfg_dack_hi = 0; qual(0);
    ptr_clr = 1; @(negedge clk); ptr_clr = 0;
    ep_rx_cnt = 7'd10; ep_rx_full = 1; cfg_en = 1;
    while (!req_on()) @(negedge clk);
    qual(1); @(negedge clk); qual(0);
    chk("R9 request drops after single beat", int'(req_on()), 0);
    repeat (5) @(negedge clk);
    cfg_en = 0;
    @(negedge clk);
    chk("R11 request off while disabled", int'(req_on()), 0);
    cfg_en = 1;
    @(negedge clk);
    chk("R11 interval cancelled on re-enable", int'(req_on()), 1);
    cfg_demand = 1;
    qual(1); @(negedge clk); qual(0);
    chk("R8 demand keeps request", int'(req_on()), 1);
    cfg_en = 0;
    #1 chk("R11 request off at once", int'(req_on()), 0);
    ep_rx_full = 0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule